// File: doc/BRIEF.md
# Dual-Enable Static Memory with Input-Change Detection

This block is an 8192-word by 8-bit static memory for use inside a synchronous design. It has two chip selects of opposite polarity, an active-low write strobe and an active-low output strobe. The bidirectional data bus is split into a write-data input, a read-data output and an output-drive flag. Every signal is sampled on a fast sampling clock, and all timing is counted in edges of that clock.

The block keeps a copy of all watched inputs: address, write data and the four strobes. When any of them differs from the copy, the current access starts over. The read output is held off until the access delay has passed again. A write runs for as long as the part is selected with the write strobe low. The word is stored at the moment the write ends, or when the address moves while the write strobe is still low. When the inputs stay unchanged for long enough, or the part is not selected, a low-power flag rises.

The access delay and the idle delay are parameters, counted in sampling-clock edges.

Top module: `dual_en_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (defaults 13 and 8, so 8192 x 8). A word stored at any address, including address 0x1FFF, reads back unchanged at that address.
- R2: The part is selected only when ceLowN is 0 and ceHigh is 1. When the last sampled strobes show it deselected: dOutEn is 0, dOut is 0 and lowPower is 1. A write strobe given while deselected stores nothing.
- R3: When selected with wrN=1 and oeN=1, dOutEn stays 0.
- R4: When selected with wrN=1 and oeN=0, and all watched inputs have been unchanged for at least ACC_CYC edges, dOutEn is 1 and dOut carries the word stored at the sampled address. At all other times dOut is 0.
- R5: When selected with wrN=0, dOutEn stays 0 whatever the level of oeN.
- R6: Any sampled change of address, write data, ceLowN, ceHigh, wrN or oeN clears the stable count. dOutEn is then 0 after that edge, and stays 0 until ACC_CYC more unchanged edges have passed.
- R7: A write stores the write data sampled at the last edge before the write ends. The write ends at the first of these: ceLowN rising, ceHigh falling, wrN rising, or an address change while still writing. In the address-change case the old address receives the word.
- R8: While selected, lowPower is 1 once the inputs have been unchanged for IDLE_CYC edges. It drops to 0 at the edge that samples a change.
- R9: With default parameters (ACC_CYC=4, IDLE_CYC=8), read data first appears at the fifth rising edge after a change is applied between edges. lowPower rises at the ninth such edge.
- R10: After reset, dOutEn is 0 and lowPower is 1. The block behaves as deselected, with a stable count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| ceLowN | input | 1 | Select, active low |
| ceHigh | input | 1 | Select, active high |
| wrN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output strobe, active low |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data, zero when not driven |
| dOutEn | output | 1 | Bus drive enable |
| lowPower | output | 1 | Idle or standby indication |

## Verification
Two functions can fall on the same edge, and both cases are provoked on purpose. In the first, the edge that ends a write (or moves the address during a write) also restarts the access count and fetches the next read. The bench provokes this by moving the address and lifting wrN in the same step. It then requires that the old word lands at the old address and that the read stays blanked for the full delay. In the second, an input change arrives on the very edge where the idle or read-ready threshold would have been reached. Random hold lengths around ACC_CYC and IDLE_CYC cover this case. A bench model of the stable count judges each edge.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef struct packed {
    logic ceLowN;
    logic ceHigh;
    logic wrN;
    logic oeN;
  } ctrlPins_t;

  typedef struct packed {
    logic commit;
    logic drive;
    logic idle;
  } sramStrobes_t;

  function automatic logic isSelected(input ctrlPins_t c);
    return !c.ceLowN && c.ceHigh;
  endfunction

  function automatic logic isWriting(input ctrlPins_t c);
    return !c.ceLowN && c.ceHigh && !c.wrN;
  endfunction

endpackage

// File: rtl/sram_sampler.sv
module sram_sampler
  import sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  ctrlPins_t         ctrlNow,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [DATA_W-1:0] lastDin,
  output ctrlPins_t         lastCtrl,
  output logic              addrChange,
  output logic              anyChange
);

  localparam ctrlPins_t RESET_CTRL = '{ceLowN: 1'b1, ceHigh: 1'b0, wrN: 1'b1, oeN: 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastDin  <= '0;
      lastCtrl <= RESET_CTRL;
    end else begin
      lastAddr <= addr;
      lastDin  <= dIn;
      lastCtrl <= ctrlNow;
    end
  end

  always_comb begin
    addrChange = (addr != lastAddr);
    anyChange  = addrChange || (dIn != lastDin) || (ctrlNow != lastCtrl);
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ACC_CYC  = 4,
  parameter int IDLE_CYC = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlPins_t    ctrlNow,
  input  ctrlPins_t    lastCtrl,
  input  logic         addrChange,
  input  logic         anyChange,
  output sramStrobes_t strobes
);

  localparam int SAT   = (ACC_CYC > IDLE_CYC) ? ACC_CYC : IDLE_CYC;
  localparam int CNT_W = (SAT < 1) ? 1 : $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] ACC_C  = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] IDLE_C = CNT_W'(IDLE_CYC);

  logic [CNT_W-1:0] stableCnt;
  logic lastSel, lastWr, nowWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt <= '0;
    end else if (anyChange) begin
      stableCnt <= '0;
    end else if (stableCnt != SAT_C) begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  always_comb begin
    lastSel = isSelected(lastCtrl);
    lastWr  = isWriting(lastCtrl);
    nowWr   = isWriting(ctrlNow);
    strobes.commit = lastWr && (!nowWr || addrChange);
    strobes.drive  = lastSel && lastCtrl.wrN && !lastCtrl.oeN && (stableCnt >= ACC_C);
    strobes.idle   = !lastSel || (stableCnt >= IDLE_C);
  end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic [DATA_W-1:0] lastDin,
  input  sramStrobes_t      strobes,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cellArray [DEPTH];
  logic [DATA_W-1:0] readReg;

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      cellArray[lastAddr] <= lastDin;
    end
    readReg <= cellArray[addr];
  end

  always_comb begin
    dOutEn = strobes.drive;
    dOut   = strobes.drive ? readReg : '0;
  end

endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int ACC_CYC  = 4,
  parameter int IDLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceLowN,
  input  logic              ceHigh,
  input  logic              wrN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              lowPower
);

  ctrlPins_t         ctrlNow, lastCtrl;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastDin;
  logic              addrChange, anyChange;
  sramStrobes_t      strobes;

  assign ctrlNow = '{ceLowN: ceLowN, ceHigh: ceHigh, wrN: wrN, oeN: oeN};

  sram_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uSampler (
    .clk(clk), .rstN(rstN), .addr(addr), .dIn(dIn), .ctrlNow(ctrlNow),
    .lastAddr(lastAddr), .lastDin(lastDin), .lastCtrl(lastCtrl),
    .addrChange(addrChange), .anyChange(anyChange)
  );

  sram_ctrl #(.ACC_CYC(ACC_CYC), .IDLE_CYC(IDLE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlNow(ctrlNow), .lastCtrl(lastCtrl),
    .addrChange(addrChange), .anyChange(anyChange), .strobes(strobes)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .addr(addr), .lastAddr(lastAddr), .lastDin(lastDin),
    .strobes(strobes), .dOut(dOut), .dOutEn(dOutEn)
  );

  assign lowPower = strobes.idle;

endmodule

// File: rtl/sram_checker.sv
module sram_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              ceLowN,
  input logic              ceHigh,
  input logic              wrN,
  input logic              oeN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn,
  input logic              lowPower
);

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    dOutEn |-> $past(!ceLowN && ceHigh && wrN && !oeN)); // R4

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ceLowN && ceHigh && !wrN) |-> !dOutEn); // R5

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(ceLowN || !ceHigh) |-> (!dOutEn && lowPower)); // R2

  AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (addr != $past(addr)) |=> !dOutEn); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((addr != $past(addr)) && !ceLowN && ceHigh) |=> !lowPower); // R8

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !dOutEn |-> (dOut == '0)); // R4

endmodule

bind dual_en_sram sram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChecker (
  .clk(clk), .rstN(rstN), .addr(addr), .ceLowN(ceLowN), .ceHigh(ceHigh),
  .wrN(wrN), .oeN(oeN), .dOut(dOut), .dOutEn(dOutEn), .lowPower(lowPower)
);

// File: tb/tb_dual_en_sram.sv
module tb_dual_en_sram;
  localparam int ADDR_W = 13, DATA_W = 8, ACC_CYC = 4, IDLE_CYC = 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic ceLowN = 1'b1, ceHigh = 1'b0, wrN = 1'b1, oeN = 1'b1;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic dOutEn, lowPower;

  dual_en_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .IDLE_CYC(IDLE_CYC)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .ceLowN(ceLowN), .ceHigh(ceHigh),
    .wrN(wrN), .oeN(oeN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn), .lowPower(lowPower)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model
  logic [DATA_W-1:0] mMem [DEPTH];
  bit                mKnown [DEPTH];
  logic [ADDR_W-1:0] mAddr = '0;
  logic [DATA_W-1:0] mDin = '0;
  logic mCeLowN = 1'b1, mCeHigh = 1'b0, mWrN = 1'b1, mOeN = 1'b1;
  int mCnt = 0;

  function automatic bit selOf(logic l, logic h);
    return !l && h;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit chg, lastWr, nowWr;
    chg = (addr != mAddr) || (dIn != mDin) || (ceLowN != mCeLowN) || (ceHigh != mCeHigh)
       || (wrN != mWrN) || (oeN != mOeN);
    lastWr = selOf(mCeLowN, mCeHigh) && !mWrN;
    nowWr  = selOf(ceLowN, ceHigh) && !wrN;
    if (lastWr && (!nowWr || addr != mAddr)) begin // R7 commit at end of write
      mMem[mAddr]   = mDin;
      mKnown[mAddr] = 1'b1;
    end
    if (chg) mCnt = 0; else if (mCnt < 1000) mCnt++;
    mAddr = addr; mDin = dIn; mCeLowN = ceLowN; mCeHigh = ceHigh; mWrN = wrN; mOeN = oeN;
  endtask

  task automatic checkOutputs();
    bit sel, expDrive, expIdle;
    string t;
    sel = selOf(mCeLowN, mCeHigh);
    expDrive = sel && mWrN && !mOeN && (mCnt >= ACC_CYC);
    expIdle  = !sel || (mCnt >= IDLE_CYC);
    if (!sel) t = "R2"; else if (!mWrN) t = "R5"; else if (mOeN) t = "R3"; else t = "R4/R6";
    check(t, dOutEn, expDrive);
    check(sel ? "R8" : "R2", lowPower, expIdle);
    if (!expDrive) check("R4", dOut, 0);
    else if (mKnown[mAddr]) check("R1", dOut, mMem[mAddr]);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      checkOutputs();
    end
  endtask

  task automatic setPins(logic [ADDR_W-1:0] a, logic l, logic h, logic w, logic o, logic [DATA_W-1:0] d);
    addr = a; ceLowN = l; ceHigh = h; wrN = w; oeN = o; dIn = d;
  endtask

  task automatic readBack(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp, string tag);
    setPins(a, 1'b0, 1'b1, 1'b1, 1'b0, dIn);
    tick(ACC_CYC + 1);
    check(tag, {dOutEn, dOut}, {1'b1, exp});
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mKnown[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", dOutEn, 1'b0);
    check("R10", lowPower, 1'b1);
    rstN = 1'b1;
    tick(2);

    // R1: top address write via wrN pulse
    setPins(13'h1FFF, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5); tick(2);
    wrN = 1'b0; tick(2);
    wrN = 1'b1; tick(1);
    // R9: read appears at fifth edge after change
    setPins(13'h1FFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5);
    tick(ACC_CYC);
    check("R9", dOutEn, 1'b0);
    tick(1);
    check("R9", dOutEn, 1'b1);
    check("R1", dOut, 8'hA5);
    tick(IDLE_CYC - ACC_CYC - 1);
    check("R9", lowPower, 1'b0);
    tick(1);
    check("R9", lowPower, 1'b1);

    // R7: data changes mid-write, ended by ceLowN rising
    setPins(13'h0003, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11); tick(2);
    dIn = 8'h22; tick(2);
    ceLowN = 1'b1; tick(1);
    readBack(13'h0003, 8'h22, "R7");
    // R7: ended by ceHigh falling
    setPins(13'h0004, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5C); tick(3);
    ceHigh = 1'b0; tick(1);
    readBack(13'h0004, 8'h5C, "R7");
    // R7: address change while writing lands old word at old address, same edge as wrN rise
    setPins(13'h0005, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77); tick(2);
    setPins(13'h0006, 1'b0, 1'b1, 1'b1, 1'b1, 8'h99); tick(1);
    readBack(13'h0005, 8'h77, "R7");
    // R2: write strobe while deselected stores nothing
    setPins(13'h0005, 1'b1, 1'b1, 1'b0, 1'b1, 8'hEE); tick(3);
    setPins(13'h0005, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEE); tick(3);
    setPins(13'h0005, 1'b1, 1'b1, 1'b1, 1'b1, 8'hEE); tick(1);
    readBack(13'h0005, 8'h77, "R2");
    // R6: address change during stable read blanks output
    setPins(13'h0003, 1'b0, 1'b1, 1'b1, 1'b0, dIn); tick(1);
    check("R6", dOutEn, 1'b0);

    // random phase, seeded
    void'($urandom(32'd20240611));
    for (int s = 0; s < 3000; s++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom % 5 == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom % 8);
      setPins(a, ($urandom % 6 == 0), ($urandom % 6 != 0), ($urandom % 3 != 0),
              ($urandom % 3 == 0), DATA_W'($urandom));
      tick(1 + ($urandom % 11));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule